// File: doc/BRIEF.md
# Double-Data-Rate Burst-of-Four Synchronous SRAM

This block is a synthesizable cycle-level model of the device side of a pipelined double-data-rate SRAM that moves four words per address. It runs on one beat clock `clk` at twice the rate of the logical K clock. Every rising edge of `clk` stands for one half-cycle of the K pair. The first edge after reset is a K rising edge, and the phases alternate from there. A command (load strobe, read/write select and word address) is sampled on a K rising edge. Each accepted command owns two K cycles, so commands can only be taken on every second K rising edge.

A write takes its four data words on the four half-cycle edges that follow the command edge. Each word carries two active-low half-word write selects. A read returns its four words on consecutive half-cycles, starting 1.5 K cycles after the command edge. The burst index is two bits wide and runs sequentially, wrapping inside the aligned group of four. In the wide configurations it starts from the two low address bits. In the byte-wide configuration (`DW` = 8) it always starts from zero. A pair of complementary echo clocks runs alongside the output data so a receiver can capture it. A small internal array stands in for the storage core.

Top module: `sram_ddr_burst4`

## Requirements
- R1: On an edge that is a K rising edge (the first edge after reset, then every second edge), `ld_n` low starts a command. `rw` high selects a read and `rw` low selects a write.
- R2: On the K rising edge that follows an accepted command, `ld_n` is ignored. `ld_n` is also ignored on every K-complement edge.
- R3: Within a burst the word index runs start, start+1, start+2, start+3, modulo 4, inside the aligned group of four words given by `addr[AW-1:2]`.
- R4: The start index is `addr[1:0]` when `DW` is not 8. It is 00 when `DW` is 8.
- R5: For a write accepted at edge E, beat k (k = 0..3) is taken from `wdata` and `wsel_n` at edge E+1+k.
- R6: `wsel_n[0]` low writes bits `DW/2-1:0` of the beat and `wsel_n[1]` low writes bits `DW-1:DW/2`. A half whose select is high keeps its stored value.
- R7: For a read accepted at edge E, beat k is registered onto `q` with `q_valid` high at edge E+3+k. Outside read beats, `q_valid` is low and `q` is zero.
- R8: A read accepted on the K rising edge right after a write burst to the same address returns the newly written words. A read accepted directly before a write to the same address returns the old words.
- R9: `cq` goes high at each K rising edge and low at each K-complement edge. `cq_n` is always its complement.
- R10: While reset is asserted, `q` is 0, `q_valid` is 0, `cq` is 0 and `cq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, one rising edge per K half-cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Active-low command load strobe |
| rw | input | 1 | Command type: 1 read, 0 write |
| addr | input | AW | Word address; low two bits give the burst start in wide configurations |
| wdata | input | DW | Write data beat |
| wsel_n | input | 2 | Active-low half-word write selects, low half on bit 0 |
| q | output | DW | Read data beat, zero when idle |
| q_valid | output | 1 | High while `q` carries a read beat |
| cq | output | 1 | Echo clock, high after K rising edges |
| cq_n | output | 1 | Complementary echo clock |

## Verification
The bench builds two instances side by side from the same stimulus: one with `DW` = 18 and one with `DW` = 8, both with `AW` = 6. The wide instance exercises all four start offsets and the wrap of the sequential index. The byte-wide instance shows that the same addresses always burst from zero, and the two instances differ in the width of their write-select halves. Back-to-back write/read and read/write pairs to one address expose ordering between the write beats and the read launch. Stray load strobes on blocked and complement edges probe the command spacing.

// File: rtl/sram_ddr_pkg.sv
package sram_ddr_pkg;

    localparam int BURST_LEN = 4;

    typedef logic [1:0] beat_t;

    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_READ  = 1'b1
    } op_e;

endpackage

// File: rtl/sram_ddr_ctrl.sv
module sram_ddr_ctrl
    import sram_ddr_pkg::*;
#(
    parameter int AW     = 6,
    parameter bit NARROW = 1'b0,
    parameter int RD_LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_n,
    input  logic          rw,
    input  logic [AW-1:0] addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_idx,
    output logic          rd_en,
    output logic [AW-1:0] rd_idx,
    output logic          k_rise
);

    localparam int BW = AW - 2;
    localparam int CW = $clog2(BURST_LEN) + 1;

    typedef struct packed {
        logic          v;
        logic [BW-1:0] base;
        beat_t         start;
    } rd_cmd_t;

    typedef struct packed {
        logic                    ph;
        logic                    gap;
        logic [CW-1:0]           wr_left;
        logic [BW-1:0]           wr_base;
        beat_t                   wr_beat;
        rd_cmd_t [RD_LAT-1:0]    rd_pipe;
        logic [CW-1:0]           rd_left;
        logic [BW-1:0]           rd_base;
        beat_t                   rd_beat;
    } ctrl_t;

    ctrl_t   s_d, s_q;
    logic    accept;
    op_e     op;
    beat_t   start;
    rd_cmd_t head;

    always_comb begin
        s_d      = s_q;
        op       = op_e'(rw);
        k_rise   = ~s_q.ph;
        s_d.ph   = ~s_q.ph;

        // command slot: K rising edge not blocked by the previous burst
        accept = k_rise & ~s_q.gap & ~ld_n;
        if (k_rise) begin
            s_d.gap = accept;
        end
        start = NARROW ? 2'b00 : addr[1:0];

        // write beats follow the command edge
        wr_en  = (s_q.wr_left != '0);
        wr_idx = {s_q.wr_base, s_q.wr_beat};
        if (wr_en) begin
            s_d.wr_left = s_q.wr_left - 1'b1;
            s_d.wr_beat = s_q.wr_beat + 1'b1;
        end
        if (accept && op == OP_WRITE) begin
            s_d.wr_left = CW'(BURST_LEN);
            s_d.wr_base = addr[AW-1:2];
            s_d.wr_beat = start;
        end

        // read command delay line
        s_d.rd_pipe[0] = '{v: accept && op == OP_READ, base: addr[AW-1:2], start: start};
        for (int i = 1; i < RD_LAT; i++) begin
            s_d.rd_pipe[i] = s_q.rd_pipe[i-1];
        end
        head = s_q.rd_pipe[RD_LAT-1];

        // read beat launch
        rd_en  = 1'b0;
        rd_idx = {s_q.rd_base, s_q.rd_beat};
        if (head.v) begin
            rd_en       = 1'b1;
            rd_idx      = {head.base, head.start};
            s_d.rd_left = CW'(BURST_LEN - 1);
            s_d.rd_base = head.base;
            s_d.rd_beat = head.start + 1'b1;
        end else if (s_q.rd_left != '0) begin
            rd_en       = 1'b1;
            s_d.rd_left = s_q.rd_left - 1'b1;
            s_d.rd_beat = s_q.rd_beat + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_CMD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 !accept);  // R2

    AST_WR_FOUR_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_WRITE) |=> wr_en ##1 wr_en ##1 wr_en ##1 wr_en);  // R5

    AST_RD_FOUR_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        head.v |-> rd_en ##1 rd_en ##1 rd_en ##1 rd_en);  // R7

endmodule

// File: rtl/sram_ddr_array.sv
module sram_ddr_array #(
    parameter int AW = 6,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          we,
    input  logic [1:0]    wmask,
    input  logic [AW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ridx,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;
    localparam int HW    = DW / 2;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int h = 0; h < 2; h++) begin
                if (wmask[h]) begin
                    mem[widx][h*HW +: HW] <= wdata[h*HW +: HW];
                end
            end
        end
    end

    assign rdata = mem[ridx];

endmodule

// File: rtl/sram_ddr_out.sv
module sram_ddr_out #(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          k_rise,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] q,
    output logic          q_valid,
    output logic          cq,
    output logic          cq_n
);

    typedef struct packed {
        logic [DW-1:0] q;
        logic          qv;
        logic          cq;
        logic          cqn;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d.q   = launch ? rdata : '0;
        o_d.qv  = launch;
        o_d.cq  = k_rise;
        o_d.cqn = ~k_rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '{q: '0, qv: 1'b0, cq: 1'b0, cqn: 1'b1};
        end else begin
            o_q <= o_d;
        end
    end

    assign q       = o_q.q;
    assign q_valid = o_q.qv;
    assign cq      = o_q.cq;
    assign cq_n    = o_q.cqn;

    AST_ECHO_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
        cq != cq_n);  // R9

    AST_ECHO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cq |=> !cq);  // R9

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |-> q == '0);  // R7

endmodule

// File: rtl/sram_ddr_burst4.sv
module sram_ddr_burst4 #(
    parameter int DW = 18,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_n,
    input  logic          rw,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [1:0]    wsel_n,
    output logic [DW-1:0] q,
    output logic          q_valid,
    output logic          cq,
    output logic          cq_n
);

    localparam bit NARROW = (DW == 8);
    localparam int RD_LAT = 3;

    logic          wr_en;
    logic [AW-1:0] wr_idx;
    logic          rd_en;
    logic [AW-1:0] rd_idx;
    logic          k_rise;
    logic [DW-1:0] rdata;

    sram_ddr_ctrl #(
        .AW     (AW),
        .NARROW (NARROW),
        .RD_LAT (RD_LAT)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_n   (ld_n),
        .rw     (rw),
        .addr   (addr),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .rd_en  (rd_en),
        .rd_idx (rd_idx),
        .k_rise (k_rise)
    );

    sram_ddr_array #(
        .AW (AW),
        .DW (DW)
    ) u_array (
        .clk   (clk),
        .we    (wr_en),
        .wmask (~wsel_n),
        .widx  (wr_idx),
        .wdata (wdata),
        .ridx  (rd_idx),
        .rdata (rdata)
    );

    sram_ddr_out #(
        .DW (DW)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (rd_en),
        .k_rise  (k_rise),
        .rdata   (rdata),
        .q       (q),
        .q_valid (q_valid),
        .cq      (cq),
        .cq_n    (cq_n)
    );

endmodule

// File: tb/sram_ddr_burst4_tb.sv
module sram_ddr_burst4_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NE         = 1024;

    logic        clk;
    logic        rst_n;
    logic        ld_n;
    logic        rw;
    logic [5:0]  addr;
    logic [17:0] wdata;
    logic [1:0]  wsel_n;
    logic [17:0] q_w;
    logic        qv_w, cq_w, cqn_w;
    logic [7:0]  q_n;
    logic        qv_n, cq_n8, cqn_n8;

    sram_ddr_burst4 #(.DW(18), .AW(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
        .wdata(wdata), .wsel_n(wsel_n),
        .q(q_w), .q_valid(qv_w), .cq(cq_w), .cq_n(cqn_w)
    );

    sram_ddr_burst4 #(.DW(8), .AW(6)) u_dut_n (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
        .wdata(wdata[7:0]), .wsel_n(wsel_n),
        .q(q_n), .q_valid(qv_n), .cq(cq_n8), .cq_n(cqn_n8)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- stimulus schedule ----------------
    bit          ld_s [NE];
    bit          rw_s [NE];
    logic [5:0]  ad_s [NE];
    logic [17:0] wd_s [NE];
    logic [1:0]  ws_s [NE];

    // mp < 0: select pattern follows the beat number, else constant
    task automatic plan(input int e, input bit r, input int a, input int mp);
        ld_s[e] = 1'b0;
        rw_s[e] = r;
        ad_s[e] = 6'(a);
        if (!r) begin
            for (int k = 0; k < 4; k++) begin
                wd_s[e+1+k] = 18'($urandom);
                ws_s[e+1+k] = (mp < 0) ? 2'(k) : 2'(mp);
            end
        end
    endtask

    task automatic stray(input int e);
        ld_s[e] = 1'b0;
        rw_s[e] = 1'($urandom);
        ad_s[e] = 6'($urandom);
    endtask

    // ---------------- behavioural reference ----------------
    typedef struct { int e; int i18; int i8; } ent_t;
    ent_t        rq [$];
    ent_t        wq [$];
    logic [17:0] m18 [64];
    logic [7:0]  m8  [64];
    int          me    = 0;
    bit          m_gap = 1'b0;
    bit          m_kr, m_acc;
    bit          exp_v   = 1'b0;
    logic [17:0] exp_q18 = '0;
    logic [7:0]  exp_q8  = '0;
    bit          exp_cq  = 1'b0;
    ent_t        en;

    always @(posedge clk) begin
        if (rst_n) begin
            m_kr  = (me % 2 == 0);                    // R1: even edges are K rises
            m_acc = m_kr && !m_gap && !ld_n;          // R2: spacing rule
            if (m_kr) m_gap = m_acc;
            exp_v = 1'b0; exp_q18 = '0; exp_q8 = '0;
            if (rq.size() > 0 && rq[0].e == me) begin
                exp_v   = 1'b1;
                exp_q18 = m18[rq[0].i18];
                exp_q8  = m8[rq[0].i8];
                void'(rq.pop_front());
            end
            if (wq.size() > 0) begin                  // R5, R6
                en = wq.pop_front();
                m18[en.i18] = {wsel_n[1] ? m18[en.i18][17:9] : wdata[17:9],
                               wsel_n[0] ? m18[en.i18][8:0]  : wdata[8:0]};
                m8[en.i8]   = {wsel_n[1] ? m8[en.i8][7:4] : wdata[7:4],
                               wsel_n[0] ? m8[en.i8][3:0] : wdata[3:0]};
            end
            if (m_acc) begin
                for (int k = 0; k < 4; k++) begin
                    en.e   = me + 3 + k;                               // R7
                    en.i18 = int'(addr[5:2]) * 4 + ((int'(addr[1:0]) + k) % 4); // R3
                    en.i8  = int'(addr[5:2]) * 4 + k;                  // R4
                    if (rw) rq.push_back(en);
                    else    wq.push_back(en);
                end
            end
            exp_cq = m_kr;
            me++;
        end
    end

    // ---------------- driver and comparison ----------------
    initial begin
        int e;
        for (int i = 0; i < NE; i++) begin
            ld_s[i] = 1'b1; rw_s[i] = 1'b0; ad_s[i] = '0; wd_s[i] = '0; ws_s[i] = 2'b11;
        end
        // fill every word with full-mask writes from start 0
        for (int g = 0; g < 16; g++) plan(4*g, 1'b0, 4*g, 0);
        // remaining start offsets, with ignored strobes on blocked/complement edges
        plan(64, 1'b0, 9, 0);  stray(66); stray(69);
        plan(68, 1'b0, 22, 0);
        plan(72, 1'b0, 35, 0);
        plan(76, 1'b1, 9, 0);  stray(78); stray(77);
        plan(80, 1'b1, 22, 0);
        plan(84, 1'b1, 35, 0);
        plan(88, 1'b1, 0, 0);
        // mixed half-word selects
        plan(92, 1'b0, 45, -1);
        plan(96, 1'b1, 45, 0);
        // write then read back-to-back, same address
        for (int i = 0; i < 6; i++) begin
            plan(100 + 8*i, 1'b0, 48 + (i % 4) + 4*(i/4), (i == 3) ? -1 : 0);
            plan(104 + 8*i, 1'b1, 48 + (i % 4) + 4*(i/4), 0);
        end
        // read then write, then read again
        plan(152, 1'b1, 50, 0);
        plan(156, 1'b0, 50, 0);
        plan(160, 1'b1, 50, 0);
        e = 164;
        while (e < NE - 24) begin
            int mp;
            mp = int'($urandom % 5);
            plan(e, 1'($urandom), int'($urandom % 64), (mp == 4) ? -1 : mp);
            if ($urandom % 3 == 0) stray(e + 2);
            if ($urandom % 4 == 0) stray(e + 1);
            e += 4 + 2 * int'($urandom % 3);
        end

        rst_n = 1'b0; ld_n = 1'b1; rw = 1'b0; addr = '0; wdata = '0; wsel_n = 2'b11;
        repeat (3) @(negedge clk);
        // R10 reset state, both widths
        chk(q_w == '0 && q_n == '0, "R10 q in reset", {q_w, q_n}, 0);
        chk(!qv_w && !qv_n, "R10 q_valid in reset", {qv_w, qv_n}, 0);
        chk(!cq_w && !cq_n8, "R10 cq in reset", {cq_w, cq_n8}, 0);
        chk(cqn_w && cqn_n8, "R10 cq_n in reset", {cqn_w, cqn_n8}, 3);
        rst_n = 1'b1;
        for (int k = 0; k < NE; k++) begin
            ld_n = ld_s[k]; rw = rw_s[k]; addr = ad_s[k]; wdata = wd_s[k]; wsel_n = ws_s[k];
            @(posedge clk);
            @(negedge clk);
            chk(qv_w == exp_v, "R1 R2 R7 q_valid wide", qv_w, exp_v);
            chk(qv_n == exp_v, "R1 R2 R7 q_valid narrow", qv_n, exp_v);
            chk(q_w == exp_q18, "R3 R4 R5 R6 R8 data wide", q_w, exp_q18);
            chk(q_n == exp_q8, "R3 R4 R6 R8 data narrow", q_n, exp_q8);
            chk(cq_w == exp_cq && cq_n8 == exp_cq, "R9 cq", {cq_w, cq_n8}, {exp_cq, exp_cq});
            chk(cqn_w == !exp_cq && cqn_n8 == !exp_cq, "R9 cq_n", {cqn_w, cqn_n8}, {!exp_cq, !exp_cq});
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule